// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns a store to the software-interrupt trigger register into a request to mark an interrupt pending on a set of processors. A processor writes one 32-bit word; the block pulls the interrupt number and a two-bit routing selector out of it. Using the index of the processor that made the store, it works out which processors are addressed, and then issues a one-cycle set-pending strobe that carries the interrupt number and the processor mask. The pending store and the priority arbiter sit downstream. They OR the mask into the pending bits of that interrupt and then re-run arbitration when the strobe fires.

The routing selector has four codes. Code 0 sends to an explicit processor list carried in the word. Code 1 sends to the writer alone. Code 2 sends to every implemented processor except the writer. Code 3 is not a legal code, and the block treats it as "all processors", raising a one-cycle fallback flag when it does. A store narrower than a word is refused, and the block flags it as a size error. A store whose target set works out to empty produces no strobe at all.

Top module: `swint_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sp_valid`, `filt_fallback` and `size_err` are low.
- R2: A store with `wr_en` high and `wr_size` = 2 (word), selector code 0 in bits 25:24, produces `sp_valid` high in the cycle after the store. `sp_id` is bits 9:0 of the data, and `sp_mask` is bits 23:16 of the data limited to the low NCPU bits (bit i of the list is processor i).
- R3: When the computed mask is all zero (for example a code-0 list whose only set bits lie at or above NCPU), no strobe is produced and no output changes from idle.
- R4: Selector code 1 gives a mask with only bit `wr_cpu` set.
- R5: Selector code 2 gives a mask with every bit below NCPU set except bit `wr_cpu`.
- R6: Selector code 3 gives a mask with all NCPU bits set, and `filt_fallback` is high in the same cycle as that strobe.
- R7: A store with `wr_size` other than 2 (0 = byte, 1 = halfword, 3 = reserved) raises `size_err` for one cycle in the following cycle. It produces neither `sp_valid` nor `filt_fallback`.
- R8: Each output pulse lasts exactly one cycle. With `wr_en` low, all three strobes are low in the next cycle.
- R9: Data bits 15:10 and 31:26 have no effect on `sp_id` or `sp_mask`.
- R10: Stores on consecutive cycles each produce their own strobe on consecutive cycles, with their own number and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store strobe to the trigger register |
| wr_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| wr_data | input | 32 | Stored word |
| wr_cpu | input | CPU_W (2) | Index of the storing processor |
| sp_valid | output | 1 | One-cycle set-pending strobe |
| sp_id | output | 10 | Interrupt number carried by the strobe |
| sp_mask | output | NCPU (4) | Processors whose pending bit is to be set |
| filt_fallback | output | 1 | Reserved selector code was remapped to all processors |
| size_err | output | 1 | Store was narrower than a word and was dropped |

## Verification
A wrong decode or mask state shows up at the ports one cycle after the store. It appears as a wrong processor mask, a wrong interrupt number, a missing strobe, or a stray strobe for an empty target set. Stale state shows up as a strobe that survives into a cycle with no store. The scoreboard compares every cycle after reset, not only cycles that carry a strobe, so a pulse that is too long or comes from nowhere is caught in the first cycle it appears. Every selector code is run from more than one writer index, because a wrong comparison against the writer index only shows for some writers.

// File: rtl/swint_pkg.sv
package swint_pkg;

  // Field layout of the trigger word; downstream software depends on it.
  localparam int ID_W      = 10;
  localparam int ID_LSB    = 0;
  localparam int LIST_W    = 8;
  localparam int LIST_LSB  = 16;
  localparam int MODE_LSB  = 24;
  localparam int DATA_W    = 32;

  typedef enum logic [1:0] {
    TGT_LIST   = 2'd0,
    TGT_SELF   = 2'd1,
    TGT_OTHERS = 2'd2,
    TGT_RSVD   = 2'd3
  } tgt_mode_e;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

endpackage

// File: rtl/swint_field_decode.sv
module swint_field_decode
  import swint_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic              en_i,
  output logic [ID_W-1:0]   id_o,
  output tgt_mode_e         mode_o,
  output logic [LIST_W-1:0] list_o,
  output logic              word_go_o,
  output logic              bad_size_o
);

  logic is_word;
  logic unused_bits;

  always_comb begin
    id_o       = data_i[ID_LSB +: ID_W];
    list_o     = data_i[LIST_LSB +: LIST_W];
    mode_o     = tgt_mode_e'(data_i[MODE_LSB +: 2]);
    is_word    = (size_i == ACC_WORD);
    word_go_o  = en_i && is_word;
    bad_size_o = en_i && !is_word;
  end

  // Fields outside the decoded ranges carry no meaning.
  assign unused_bits = ^{data_i[DATA_W-1:MODE_LSB+2], data_i[LIST_LSB-1:ID_LSB+ID_W]};

endmodule

// File: rtl/swint_target_mask.sv
module swint_target_mask
  import swint_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  tgt_mode_e         mode_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic [CPU_W-1:0]  cpu_i,
  output logic [NCPU-1:0]   mask_o,
  output logic              fallback_o
);

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic is_writer;
    logic listed;

    assign is_writer = (cpu_i == CPU_W'(i));

    if (i < LIST_W) begin : g_in_list
      assign listed = list_i[i];
    end else begin : g_beyond_list
      assign listed = 1'b0;
    end

    always_comb begin
      unique case (mode_i)
        TGT_LIST:   mask_o[i] = listed;
        TGT_SELF:   mask_o[i] = is_writer;
        TGT_OTHERS: mask_o[i] = !is_writer;
        default:    mask_o[i] = 1'b1;
      endcase
    end
  end

  assign fallback_o = (mode_i == TGT_RSVD);

endmodule

// File: rtl/swint_pulse_reg.sv
module swint_pulse_reg
  import swint_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic            bad_size_i,
  input  logic            fallback_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [NCPU-1:0] mask_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o,
  output logic [NCPU-1:0] mask_o,
  output logic            fallback_o,
  output logic            size_err_o
);

  logic            valid_nxt;
  logic            fallback_nxt;
  logic            size_err_nxt;
  logic            load_en;

  always_comb begin
    valid_nxt    = go_i && (|mask_i);
    fallback_nxt = go_i && fallback_i;
    size_err_nxt = bad_size_i;
    load_en      = valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o    <= 1'b0;
      fallback_o <= 1'b0;
      size_err_o <= 1'b0;
    end else begin
      valid_o    <= valid_nxt;
      fallback_o <= fallback_nxt;
      size_err_o <= size_err_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_o   <= '0;
      mask_o <= '0;
    end else if (load_en) begin
      id_o   <= id_i;
      mask_o <= mask_i;
    end
  end

  // R3
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (mask_o != '0));

  // R7
  size_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err_o |-> (!valid_o && !fallback_o));

  // R6
  fallback_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_o |-> (valid_o && (&mask_o)));

endmodule

// File: rtl/swint_dispatch.sv
module swint_dispatch
  import swint_pkg::*;
#(
  parameter int NCPU  = 4,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CPU_W-1:0]  wr_cpu,
  output logic              sp_valid,
  output logic [ID_W-1:0]   sp_id,
  output logic [NCPU-1:0]   sp_mask,
  output logic              filt_fallback,
  output logic              size_err
);

  logic [ID_W-1:0]   dec_id;
  tgt_mode_e         dec_mode;
  logic [LIST_W-1:0] dec_list;
  logic              dec_go;
  logic              dec_bad_size;
  logic [NCPU-1:0]   tgt_mask;
  logic              tgt_fallback;

  swint_field_decode u_decode (
    .data_i     (wr_data),
    .size_i     (wr_size),
    .en_i       (wr_en),
    .id_o       (dec_id),
    .mode_o     (dec_mode),
    .list_o     (dec_list),
    .word_go_o  (dec_go),
    .bad_size_o (dec_bad_size)
  );

  swint_target_mask #(.NCPU(NCPU), .CPU_W(CPU_W)) u_mask (
    .mode_i     (dec_mode),
    .list_i     (dec_list),
    .cpu_i      (wr_cpu),
    .mask_o     (tgt_mask),
    .fallback_o (tgt_fallback)
  );

  swint_pulse_reg #(.NCPU(NCPU)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (dec_go),
    .bad_size_i (dec_bad_size),
    .fallback_i (tgt_fallback),
    .id_i       (dec_id),
    .mask_i     (tgt_mask),
    .valid_o    (sp_valid),
    .id_o       (sp_id),
    .mask_o     (sp_mask),
    .fallback_o (filt_fallback),
    .size_err_o (size_err)
  );

  // R8
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid |-> $past(wr_en && (wr_size == ACC_WORD)));

  // R2
  id_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid |-> (sp_id == $past(wr_data[ID_LSB +: ID_W])));

  // R4
  self_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_valid && ($past(wr_data[MODE_LSB +: 2]) == 2'd1)) |-> ($countones(sp_mask) == 1));

  // R7
  size_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> $past(wr_en && (wr_size != ACC_WORD)));

endmodule

// File: tb/swint_dispatch_tb_top.sv
`timescale 1ns/1ps
module swint_dispatch_tb_top;

  localparam int NCPU  = 4;
  localparam int CPU_W = 2;
  localparam logic [NCPU-1:0] ALL = '1;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [1:0]        wr_size;
  logic [31:0]       wr_data;
  logic [CPU_W-1:0]  wr_cpu;
  logic              sp_valid;
  logic [9:0]        sp_id;
  logic [NCPU-1:0]   sp_mask;
  logic              filt_fallback;
  logic              size_err;

  typedef struct {
    logic            valid;
    logic [9:0]      id;
    logic [NCPU-1:0] mask;
    logic            fb;
    logic            se;
    string           req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk;
  int   n_fail;
  bit   done;

  swint_dispatch #(.NCPU(NCPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
    .wr_data(wr_data), .wr_cpu(wr_cpu), .sp_valid(sp_valid), .sp_id(sp_id),
    .sp_mask(sp_mask), .filt_fallback(filt_fallback), .size_err(size_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk(logic [1:0] code, logic [7:0] list, logic [9:0] id);
    return {6'd0, code, list, 6'd0, id};
  endfunction

  task automatic compare(exp_t e);
    n_chk++;
    if (sp_valid !== e.valid || size_err !== e.se || filt_fallback !== e.fb ||
        (e.valid && (sp_id !== e.id || sp_mask !== e.mask))) begin
      n_fail++;
      $display("FAIL %s: got valid=%b id=%h mask=%b fb=%b se=%b, expected valid=%b id=%h mask=%b fb=%b se=%b",
               e.req, sp_valid, sp_id, sp_mask, filt_fallback, size_err,
               e.valid, e.id, e.mask, e.fb, e.se);
    end
  endtask

  // Driver: present one store on a falling edge and queue what the requirements predict.
  task automatic put(logic [1:0] size, logic [31:0] data, logic [CPU_W-1:0] cpu,
                     logic [NCPU-1:0] mask, logic fb, logic se, string req);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b1; wr_size = size; wr_data = data; wr_cpu = cpu;
    e.valid = !se && (mask != '0);
    e.id    = data[9:0];
    e.mask  = mask;
    e.fb    = fb;
    e.se    = se;
    e.req   = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en = 1'b0; wr_data = 32'hDEAD_BEEF; wr_size = 2'd2;
    end
  endtask

  // Monitor: one comparison each cycle, shortly after the active edge.
  initial begin
    exp_t idle_e;
    idle_e.valid = 0; idle_e.id = '0; idle_e.mask = '0; idle_e.fb = 0; idle_e.se = 0;
    idle_e.req = "R8 idle";
    forever begin
      @(posedge clk); #1;
      if (done) break;
      if (rst_n) begin
        if (exp_q.size() > 0) compare(exp_q.pop_front());
        else compare(idle_e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_size = 2'd2; wr_data = '0; wr_cpu = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    n_chk++;
    if (sp_valid !== 1'b0 || size_err !== 1'b0 || filt_fallback !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got valid=%b fb=%b se=%b, expected 0 0 0", sp_valid, filt_fallback, size_err);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 explicit list
    put(2'd2, mk(2'd0, 8'h05, 10'h123), 2'd0, 4'b0101, 0, 0, "R2 list 05");
    idle(1);
    put(2'd2, mk(2'd0, 8'hFF, 10'h3FF), 2'd3, 4'b1111, 0, 0, "R2 list FF masked");
    idle(1);
    // R3 empty target set
    put(2'd2, mk(2'd0, 8'hF0, 10'h011), 2'd1, 4'b0000, 0, 0, "R3 list above NCPU");
    put(2'd2, mk(2'd0, 8'h00, 10'h012), 2'd1, 4'b0000, 0, 0, "R3 empty list");
    idle(1);
    // R4 self
    put(2'd2, mk(2'd1, 8'hFF, 10'h00A), 2'd2, 4'b0100, 0, 0, "R4 self cpu2");
    idle(1);
    put(2'd2, mk(2'd1, 8'h00, 10'h00B), 2'd0, 4'b0001, 0, 0, "R4 self cpu0");
    idle(1);
    // R5 all others
    put(2'd2, mk(2'd2, 8'h00, 10'h040), 2'd1, 4'b1101, 0, 0, "R5 others cpu1");
    idle(1);
    put(2'd2, mk(2'd2, 8'h0F, 10'h041), 2'd3, 4'b0111, 0, 0, "R5 others cpu3");
    idle(1);
    // R6 reserved code
    put(2'd2, mk(2'd3, 8'h00, 10'h200), 2'd2, 4'b1111, 1, 0, "R6 reserved code");
    idle(1);
    // R7 narrow accesses
    put(2'd0, mk(2'd1, 8'h00, 10'h001), 2'd0, 4'b0001, 0, 1, "R7 byte");
    idle(1);
    put(2'd1, mk(2'd3, 8'h00, 10'h002), 2'd0, 4'b1111, 0, 1, "R7 halfword");
    idle(1);
    put(2'd3, mk(2'd0, 8'h03, 10'h003), 2'd0, 4'b0011, 0, 1, "R7 reserved size");
    idle(2);
    // R9 ignored bits
    put(2'd2, 32'hFC0A_FC55, 2'd1, 4'b1010, 0, 0, "R9 junk bits");
    idle(1);
    // R10 back-to-back, then R8 idle
    put(2'd2, mk(2'd1, 8'h00, 10'h101), 2'd3, 4'b1000, 0, 0, "R10 burst a");
    put(2'd2, mk(2'd2, 8'h00, 10'h102), 2'd0, 4'b1110, 0, 0, "R10 burst b");
    put(2'd2, mk(2'd3, 8'h00, 10'h103), 2'd1, 4'b1111, 1, 0, "R10 burst c");
    put(2'd0, mk(2'd0, 8'h01, 10'h104), 2'd1, 4'b0001, 0, 1, "R10 burst d");
    put(2'd2, mk(2'd0, 8'h0C, 10'h105), 2'd2, 4'b1100, 0, 0, "R10 burst e");
    idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule